// File: doc/BRIEF.md
# Layer-Chaining Buffer Write Controller

This controller sits between a decompression stage, a convolution datapath and the two on-chip buffers that feed that datapath: a weight buffer and an input buffer. For every convolution layer it takes one descriptor holding a source tensor ID, a destination tensor ID and a weight-hold flag. It then drives the single write port of each buffer in turn, one entry per cycle. When the layer about to run reads the tensor that the previous layer produced, the controller routes the convolution results back into the input buffer, so that tensor is not fetched from memory again. Otherwise the input buffer is filled from the decompressed stream. Any result that is not chained back is never written.

Each write address doubles as the read index presented to the data sources. The decompressed weight word, the decompressed input word and the convolution result for that index must be valid on the data inputs in the same cycle. A layer runs through four states. IDLE waits for a descriptor (transition *accept*). WLOAD reloads every weight entry (transition *weights_done*). ILOAD fills every input entry from the selected source (transition *inputs_done*). DONE raises the completion pulse for one cycle (transition *release*) and returns to IDLE. An accepted descriptor with the hold flag set goes from IDLE straight to ILOAD (transition *accept_hold*).

Top module: `chain_buf_ctrl`

## Requirements
- R1: `desc_ready` is high only in IDLE, and a descriptor is taken on a cycle where `desc_valid` and `desc_ready` are both high. While a layer is in progress, `desc_ready` stays low.
- R2: An accepted layer is chained (`ibuf_sel` = 1) when its source ID equals the destination ID of the previously accepted layer.
- R3: After reset no destination ID is remembered, so the first layer after reset always loads fresh input, even when its source ID is 0.
- R4: For a chained layer, input-buffer entry i receives `res_data` presented at index i, and `ibuf_sel` stays at 1 for the whole fill.
- R5: For an unchained layer, input-buffer entry i receives `isrc_data` presented at index i (`ibuf_sel` = 0), and the convolution result is written nowhere.
- R6: With the hold flag clear, the weight buffer is rewritten at addresses 0 to WBUF_DEPTH-1 in ascending order, each from `wsrc_data`. Every weight write happens before the first input write.
- R7: With the hold flag set, no weight write occurs and the weight buffer keeps its previous contents.
- R8: At most one buffer is written per cycle. An input fill writes addresses 0 to IBUF_DEPTH-1 in ascending order, each exactly once.
- R9: `layer_done` is a one-cycle pulse in the cycle after the last input write. It comes WBUF_DEPTH+IBUF_DEPTH+1 cycles after acceptance, or IBUF_DEPTH+1 cycles when weights are held.
- R10: Every accepted descriptor replaces the remembered destination ID, whether or not that layer was itself chained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the remembered destination ID |
| desc_valid | input | 1 | Layer descriptor valid |
| desc_ready | output | 1 | Controller idle and able to take a descriptor |
| desc_src_id | input | ID_W | Tensor ID this layer reads |
| desc_dst_id | input | ID_W | Tensor ID this layer produces |
| desc_wkeep | input | 1 | 1: hold the weight buffer; 0: reload it |
| wsrc_data | input | DATA_W | Decompressed weight word for index `wbuf_waddr` |
| isrc_data | input | DATA_W | Decompressed input word for index `ibuf_waddr` |
| res_data | input | DATA_W | Convolution result word for index `ibuf_waddr` |
| wbuf_we | output | 1 | Weight buffer write enable |
| wbuf_waddr | output | WA_W | Weight buffer write address / source read index |
| wbuf_wdata | output | DATA_W | Weight buffer write data |
| ibuf_we | output | 1 | Input buffer write enable |
| ibuf_waddr | output | IA_W | Input buffer write address / source read index |
| ibuf_wdata | output | DATA_W | Input buffer write data |
| ibuf_sel | output | 1 | Input source select: 1 result, 0 decompressed stream |
| layer_done | output | 1 | One-cycle layer completion pulse |

## Verification
A wrong remembered destination ID shows up on the very next layer. `ibuf_sel` takes the wrong value in the first input-write cycle, and every entry of the bench's model buffer then carries the wrong source pattern. A counter or state fault shows as a gap, a repeat or a missing address in the write sequence. It can also show as a weight write after an input write, or as `layer_done` arriving early or late against the cycle count from acceptance. All of these are visible within one layer of the fault. A hold flag that is ignored shows as extra weight writes that overwrite a pattern the bench still expects.

// File: rtl/chain_ctrl_pkg.sv
package chain_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WLOAD = 2'd1,
        ST_ILOAD = 2'd2,
        ST_DONE  = 2'd3
    } ctrl_state_t;

endpackage

// File: rtl/chain_fill_counter.sv
module chain_fill_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] last_idx,
    output logic [CNT_W-1:0] idx,
    output logic             at_last
);

    assign at_last = (idx == last_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (step) begin
            idx <= at_last ? '0 : idx + 1'b1;
        end
    end

    // The index never runs past the limit it is stepping towards
    assert_idx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !at_last) |=> (idx != '0));

endmodule

// File: rtl/chain_dep_tracker.sv
module chain_dep_tracker #(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [ID_W-1:0] src_id,
    input  logic [ID_W-1:0] dst_id,
    output logic            chain_hit
);

    logic [ID_W-1:0] prev_dst;
    logic            prev_vld;

    // R2/R3: a hit needs a remembered producer whose output ID matches
    assign chain_hit = prev_vld && (src_id == prev_dst);

    // R10: every accepted layer becomes the new producer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_dst <= '0;
            prev_vld <= 1'b0;
        end else if (capture) begin
            prev_dst <= dst_id;
            prev_vld <= 1'b1;
        end
    end

    assert_remember_dst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (prev_vld && prev_dst == $past(dst_id)));

endmodule

// File: rtl/chain_buf_ctrl.sv
module chain_buf_ctrl
    import chain_ctrl_pkg::*;
#(
    parameter int ID_W       = 4,
    parameter int DATA_W     = 16,
    parameter int WBUF_DEPTH = 8,
    parameter int IBUF_DEPTH = 12,
    localparam int WA_W      = $clog2(WBUF_DEPTH),
    localparam int IA_W      = $clog2(IBUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ID_W-1:0]   desc_src_id,
    input  logic [ID_W-1:0]   desc_dst_id,
    input  logic              desc_wkeep,
    input  logic [DATA_W-1:0] wsrc_data,
    input  logic [DATA_W-1:0] isrc_data,
    input  logic [DATA_W-1:0] res_data,
    output logic              wbuf_we,
    output logic [WA_W-1:0]   wbuf_waddr,
    output logic [DATA_W-1:0] wbuf_wdata,
    output logic              ibuf_we,
    output logic [IA_W-1:0]   ibuf_waddr,
    output logic [DATA_W-1:0] ibuf_wdata,
    output logic              ibuf_sel,
    output logic              layer_done
);

    localparam int MAX_DEPTH = (WBUF_DEPTH > IBUF_DEPTH) ? WBUF_DEPTH : IBUF_DEPTH;
    localparam int CNT_W     = $clog2(MAX_DEPTH);
    localparam logic [CNT_W-1:0] W_LAST  = CNT_W'(WBUF_DEPTH - 1);
    localparam logic [CNT_W-1:0] I_LAST  = CNT_W'(IBUF_DEPTH - 1);
    localparam logic [IA_W-1:0]  IA_LAST = IA_W'(IBUF_DEPTH - 1);

    ctrl_state_t       state_q, state_d;
    logic              accept;
    logic              chain_hit;
    logic              chain_q;
    logic              wkeep_q;
    logic              cnt_step;
    logic [CNT_W-1:0]  cnt_idx;
    logic [CNT_W-1:0]  cnt_last;
    logic              cnt_at_last;

    assign accept = desc_valid && desc_ready;

    chain_dep_tracker #(.ID_W(ID_W)) u_dep (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (accept),
        .src_id    (desc_src_id),
        .dst_id    (desc_dst_id),
        .chain_hit (chain_hit)
    );

    assign cnt_last = (state_q == ST_WLOAD) ? W_LAST : I_LAST;
    assign cnt_step = wbuf_we || ibuf_we;

    chain_fill_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .step     (cnt_step),
        .last_idx (cnt_last),
        .idx      (cnt_idx),
        .at_last  (cnt_at_last)
    );

    // State register plus per-layer decision latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chain_q <= 1'b0;
            wkeep_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                chain_q <= chain_hit;
                wkeep_q <= desc_wkeep;
            end
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = desc_wkeep ? ST_ILOAD : ST_WLOAD;
            end
            ST_WLOAD: begin
                if (cnt_at_last) state_d = ST_ILOAD;
            end
            ST_ILOAD: begin
                if (cnt_at_last) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        desc_ready = 1'b0;
        wbuf_we    = 1'b0;
        ibuf_we    = 1'b0;
        ibuf_sel   = 1'b0;
        layer_done = 1'b0;
        unique case (state_q)
            ST_IDLE:  desc_ready = 1'b1;
            ST_WLOAD: wbuf_we    = 1'b1;
            ST_ILOAD: begin
                ibuf_we  = 1'b1;
                ibuf_sel = chain_q;
            end
            ST_DONE:  layer_done = 1'b1;
            default:  desc_ready = 1'b0;
        endcase
    end

    assign wbuf_waddr = cnt_idx[WA_W-1:0];
    assign ibuf_waddr = cnt_idx[IA_W-1:0];
    assign wbuf_wdata = wsrc_data;
    assign ibuf_wdata = ibuf_sel ? res_data : isrc_data;

    assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> (!wbuf_we && !ibuf_we && !layer_done));

    assert_single_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wbuf_we && ibuf_we));

    assert_iaddr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ibuf_we && ibuf_waddr != IA_LAST) |=>
            (ibuf_we && ibuf_waddr == IA_W'($past(ibuf_waddr) + 1'b1)));

    assert_sel_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ibuf_we && $past(ibuf_we)) |-> $stable(ibuf_sel));

    assert_reload_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !desc_wkeep) |=> (wbuf_we && wbuf_waddr == '0));

    assert_hold_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && desc_wkeep) |=> (ibuf_we && !wbuf_we && ibuf_waddr == '0));

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ibuf_we && ibuf_waddr == IA_LAST) |=> layer_done);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        layer_done |=> !layer_done);

endmodule

// File: tb/chain_buf_ctrl_test.sv
`timescale 1ns/1ps
module chain_buf_ctrl_test;

    localparam int ID_W = 4;
    localparam int DW   = 16;
    localparam int WD   = 8;
    localparam int IDP  = 12;
    localparam int WA_W = $clog2(WD);
    localparam int IA_W = $clog2(IDP);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            desc_valid = 1'b0;
    logic            desc_ready;
    logic [ID_W-1:0] desc_src_id = '0;
    logic [ID_W-1:0] desc_dst_id = '0;
    logic            desc_wkeep = 1'b0;
    logic [DW-1:0]   wsrc_data, isrc_data, res_data;
    logic            wbuf_we, ibuf_we, ibuf_sel, layer_done;
    logic [WA_W-1:0] wbuf_waddr;
    logic [IA_W-1:0] ibuf_waddr;
    logic [DW-1:0]   wbuf_wdata, ibuf_wdata;

    logic [7:0] wtag = 8'h00, itag = 8'h00, rtag = 8'h00;

    assign wsrc_data = {wtag, 8'(wbuf_waddr)};
    assign isrc_data = {itag, 8'(ibuf_waddr)};
    assign res_data  = {rtag, 8'(ibuf_waddr)};

    always #4 clk = ~clk;

    chain_buf_ctrl #(.ID_W(ID_W), .DATA_W(DW), .WBUF_DEPTH(WD), .IBUF_DEPTH(IDP)) uut (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_src_id(desc_src_id), .desc_dst_id(desc_dst_id), .desc_wkeep(desc_wkeep),
        .wsrc_data(wsrc_data), .isrc_data(isrc_data), .res_data(res_data),
        .wbuf_we(wbuf_we), .wbuf_waddr(wbuf_waddr), .wbuf_wdata(wbuf_wdata),
        .ibuf_we(ibuf_we), .ibuf_waddr(ibuf_waddr), .ibuf_wdata(ibuf_wdata),
        .ibuf_sel(ibuf_sel), .layer_done(layer_done)
    );

    int tests = 0;
    int fails = 0;

    // Model buffers and write monitor (sampled at the falling edge)
    logic [DW-1:0] wmem [WD];
    logic [DW-1:0] imem [IDP];
    int wcnt, icnt, exp_wa, exp_ia, mon_err, sel_seen_hi, sel_seen_lo;

    always @(negedge clk) begin
        if (rst_n) begin
            if (wbuf_we && ibuf_we) mon_err++;
            if (wbuf_we) begin
                if (int'(wbuf_waddr) != exp_wa || icnt != 0) mon_err++;
                if (int'(wbuf_waddr) < WD) wmem[wbuf_waddr] = wbuf_wdata;
                exp_wa++;
                wcnt++;
            end
            if (ibuf_we) begin
                if (int'(ibuf_waddr) != exp_ia) mon_err++;
                if (int'(ibuf_waddr) < IDP) imem[ibuf_waddr] = ibuf_wdata;
                if (ibuf_sel) sel_seen_hi++; else sel_seen_lo++;
                exp_ia++;
                icnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            summary_and_end();
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Runs one layer and checks every requirement visible from it
    task automatic run_layer(input int src, input int dst, input bit wkeep,
                             input bit exp_chain, input int k, input string tag);
        int n;
        int exp_n;
        logic [7:0] old_wtag;
        old_wtag = wtag;
        @(negedge clk);
        wcnt = 0; icnt = 0; exp_wa = 0; exp_ia = 0; mon_err = 0;
        sel_seen_hi = 0; sel_seen_lo = 0;
        if (!wkeep) wtag = 8'(8'hA0 + k);
        itag = 8'(8'h10 + k);
        rtag = 8'(8'h50 + k);
        chk(desc_ready === 1'b1, "R1", {tag, " ready before accept"}, int'(desc_ready), 1);
        desc_valid  = 1'b1;
        desc_src_id = ID_W'(src);
        desc_dst_id = ID_W'(dst);
        desc_wkeep  = wkeep;
        @(negedge clk);
        desc_valid = 1'b0;
        desc_src_id = ID_W'(15 - src);
        chk(desc_ready === 1'b0, "R1", {tag, " ready low while busy"}, int'(desc_ready), 0);
        n = 1;
        while (layer_done !== 1'b1 && n < 300) begin
            @(negedge clk);
            n++;
        end
        exp_n = wkeep ? IDP + 1 : WD + IDP + 1;
        chk(n == exp_n, "R9", {tag, " done latency"}, n, exp_n);
        @(negedge clk);
        chk(layer_done === 1'b0, "R9", {tag, " done one cycle"}, int'(layer_done), 0);
        chk(desc_ready === 1'b1, "R1", {tag, " ready after done"}, int'(desc_ready), 1);
        chk(mon_err == 0, "R8", {tag, " write order and port use"}, mon_err, 0);
        chk(icnt == IDP, "R8", {tag, " input write count"}, icnt, IDP);
        if (exp_chain)
            chk(sel_seen_hi == IDP, "R2", {tag, " chained select"}, sel_seen_hi, IDP);
        else
            chk(sel_seen_lo == IDP, "R5", {tag, " fresh select"}, sel_seen_lo, IDP);
        for (int i = 0; i < IDP; i++) begin
            int expv;
            expv = exp_chain ? int'({rtag, 8'(i)}) : int'({itag, 8'(i)});
            chk(int'(imem[i]) == expv, exp_chain ? "R4" : "R5",
                {tag, " input entry"}, int'(imem[i]), expv);
        end
        if (wkeep) begin
            chk(wcnt == 0, "R7", {tag, " no weight writes"}, wcnt, 0);
            for (int i = 0; i < WD; i++)
                chk(int'(wmem[i]) == int'({old_wtag, 8'(i)}), "R7",
                    {tag, " weight entry kept"}, int'(wmem[i]), int'({old_wtag, 8'(i)}));
        end else begin
            chk(wcnt == WD, "R6", {tag, " weight write count"}, wcnt, WD);
            for (int i = 0; i < WD; i++)
                chk(int'(wmem[i]) == int'({wtag, 8'(i)}), "R6",
                    {tag, " weight entry reloaded"}, int'(wmem[i]), int'({wtag, 8'(i)}));
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk(desc_ready === 1'b1, "R1", "reset ready", int'(desc_ready), 1);
        chk(wbuf_we === 1'b0 && ibuf_we === 1'b0, "R8", "reset no writes",
            int'(wbuf_we) + int'(ibuf_we), 0);
        chk(layer_done === 1'b0, "R9", "reset done low", int'(layer_done), 0);
    endtask

    // R3: src 0 equals the cleared ID value, yet no chain
    task automatic t_first_fresh();
        run_layer(0, 3, 1'b0, 1'b0, 1, "R3 first layer");
    endtask

    // R2/R4/R7: dependent layer with weights held
    task automatic t_chain_hold();
        run_layer(3, 5, 1'b1, 1'b1, 2, "R2 chained hold");
    endtask

    // R5/R6: independent layer reloads weights
    task automatic t_break();
        run_layer(7, 2, 1'b0, 1'b0, 3, "R5 unchained");
    endtask

    // R10: dst remembered from an unchained layer, then from a chained one
    task automatic t_chain_again();
        run_layer(2, 2, 1'b0, 1'b1, 4, "R10 chain reload");
        run_layer(2, 9, 1'b1, 1'b1, 5, "R10 chain self");
    endtask

    // R3: reset mid-fill forgets the producer
    task automatic t_reset_mid();
        @(negedge clk);
        desc_valid = 1'b1; desc_src_id = 4'd9; desc_dst_id = 4'd6; desc_wkeep = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ibuf_we === 1'b0, "R3", "write stops in reset", int'(ibuf_we), 0);
        rst_n = 1'b1;
        run_layer(6, 1, 1'b0, 1'b0, 6, "R3 after reset");
    endtask

    initial begin
        for (int i = 0; i < WD; i++) wmem[i] = '0;
        for (int i = 0; i < IDP; i++) imem[i] = '0;
        wcnt = 0; icnt = 0; exp_wa = 0; exp_ia = 0; mon_err = 0;
        sel_seen_hi = 0; sel_seen_lo = 0;
        t_reset_state();
        t_first_fresh();
        t_chain_hold();
        t_break();
        t_chain_again();
        t_reset_mid();
        summary_and_end();
    end

endmodule